// File: doc/BRIEF.md
# Fast Lockup Timer Controller

This controller runs the short high-gain phase that a PLL uses to settle quickly after it is retuned or woken. When enabled, a new committed frequency setting or the release of the PLL section from power-down opens a boost window. While the window is open, the charge pump takes the boost current code and a loop-filter bypass switch is closed. The window closes after a programmed number of phase-detector cycles. The controller then returns the charge pump to the normal current code and opens the switch.

Time is counted in phase-detector cycles. The system clock runs much faster than the phase detector, and a one-cycle `pfd_tick` pulse marks each phase-detector period. The controller also turns the active current code into a weight given in half-minimum-current units, for the analog current source that follows.

The block is a two-state machine. `ST_IDLE` leaves the normal code on the outputs. `ST_BOOST` applies the boost code and has a down-counter running. It has three transitions:
- **start**: `ST_IDLE` to `ST_BOOST` on a trigger.
- **retrigger**: `ST_BOOST` to `ST_BOOST` on a trigger, which reloads the counter.
- **expire or abort**: `ST_BOOST` to `ST_IDLE` when the last tick is counted, or when the enable or the PLL power is removed.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset, `busy` and `loop_sw` are 0 and `cp_code` equals `cp_norm`.
- R2: When `freq_change` is 1 at a clock edge while `fast_en` and `pll_en` are both 1, `busy` is 1 from that edge onward.
- R3: When `pll_en` is sampled 1 at an edge after being sampled 0 at the previous edge (reset counts as a previous 0), and `fast_en` is 1, the boost window starts at that edge.
- R4: While `busy` is 1, `loop_sw` is 1 and `cp_code` equals `cp_boost`. Otherwise `loop_sw` is 0 and `cp_code` equals `cp_norm`.
- R5: A window loaded with length L ends at the clock edge that samples the L-th `pfd_tick` after the start edge, and `busy` reads 0 from that edge onward.
- R6: A programmed length `fast_len` of 0 acts as a length of 1.
- R7: A trigger during an open window reloads the full length. A `pfd_tick` sampled on the same edge as a trigger is not counted.
- R8: While `fast_en` is 0, no window starts, and `busy` reads 0 in the same cycle. Any open window is cancelled.
- R9: While `pll_en` is 0, `busy` reads 0 in the same cycle and any open window is cancelled.
- R10: `cp_weight` gives the current of `cp_code` in half-minimum units. A code with its top bit at 1 gives 1. Any other code c gives 2*(c+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_tick | input | 1 | One-cycle pulse for each phase-detector period |
| freq_change | input | 1 | One-cycle pulse when a new frequency setting is committed |
| pll_en | input | 1 | PLL section power level; 1 = running |
| fast_en | input | 1 | Allows boost windows to occur |
| fast_len | input | 13 | Window length in phase-detector cycles |
| cp_norm | input | 4 | Charge-pump code for normal operation |
| cp_boost | input | 4 | Charge-pump code used during the window |
| cp_code | output | 4 | Active charge-pump code |
| loop_sw | output | 1 | Loop-filter bypass switch enable |
| busy | output | 1 | High while a boost window is open |
| cp_weight | output | 5 | Active current in half-minimum-current units |

## Verification
The assertions assume the following about the inputs:
- `pfd_tick` and `freq_change` are single-cycle pulses.
- All inputs change only between clock edges.
- The only way a window can close is a counted tick or the loss of an enable.

The stimulus meets these assumptions in three ways:
- It drives every input on the falling clock edge.
- It produces ticks from a fixed period counter.
- It raises `freq_change` for exactly one cycle at a time, including the cases where a trigger and a tick land on the same edge.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BOOST = 1'b1
    } fl_state_t;
endpackage

// File: rtl/fl_rise_trig.sv
module fl_rise_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic freq_change,
    input  logic fast_en,
    output logic trig
);
    logic pll_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pll_en_q <= 1'b0;
        else        pll_en_q <= pll_en;
    end

    always_comb begin
        trig = fast_en && pll_en && (freq_change || !pll_en_q);
    end
endmodule

// File: rtl/fl_period_timer.sv
module fl_period_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             dec,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] start_val;

    always_comb begin
        start_val = (load_len == '0) ? ONE : load_len;
        expire    = dec && !load && (remain == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  remain <= ONE;
        else if (load)               remain <= start_val;
        else if (dec && remain > ONE) remain <= remain - ONE;
    end
endmodule

// File: rtl/fl_current_weight.sv
module fl_current_weight #(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W:0]   weight
);
    localparam int WT_W = CODE_W + 1;
    logic [WT_W-1:0] step;

    always_comb begin
        step = WT_W'(code[CODE_W-2:0]) + WT_W'(1);
        if (code[CODE_W-1]) weight = WT_W'(1);
        else                weight = step << 1;
    end
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
    import fastlock_pkg::*;
#(
    parameter int CNT_W  = 13,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfd_tick,
    input  logic              freq_change,
    input  logic              pll_en,
    input  logic              fast_en,
    input  logic [CNT_W-1:0]  fast_len,
    input  logic [CODE_W-1:0] cp_norm,
    input  logic [CODE_W-1:0] cp_boost,
    output logic [CODE_W-1:0] cp_code,
    output logic              loop_sw,
    output logic              busy,
    output logic [CODE_W:0]   cp_weight
);
    fl_state_t state, state_nx;
    logic trig, expire, dec, active;

    fl_rise_trig u_trig (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .freq_change(freq_change), .fast_en(fast_en), .trig(trig)
    );

    assign dec = (state == ST_BOOST) && pfd_tick;

    fl_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(trig), .load_len(fast_len),
        .dec(dec), .expire(expire)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (trig) state_nx = ST_BOOST;
            end
            ST_BOOST: begin
                if (!fast_en || !pll_en) state_nx = ST_IDLE;
                else if (trig)           state_nx = ST_BOOST;
                else if (expire)         state_nx = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        active  = (state == ST_BOOST) && fast_en && pll_en;
        busy    = active;
        loop_sw = active;
        cp_code = active ? cp_boost : cp_norm;
    end

    fl_current_weight #(.CODE_W(CODE_W)) u_weight (
        .code(cp_code), .weight(cp_weight)
    );
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pfd_tick,
    input logic              freq_change,
    input logic              pll_en,
    input logic              fast_en,
    input logic [CODE_W-1:0] cp_norm,
    input logic [CODE_W-1:0] cp_boost,
    input logic [CODE_W-1:0] cp_code,
    input logic              loop_sw,
    input logic              busy,
    input logic [CODE_W:0]   cp_weight
);
    p_start_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_change && fast_en && pll_en) |=> (busy || !fast_en || !pll_en));

    p_switch_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sw == busy);

    p_boost_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cp_code == cp_boost));

    p_norm_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cp_code == cp_norm));

    p_end_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!fast_en || !pll_en || $past(pfd_tick)));

    p_gate_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |-> !busy);

    p_gate_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> !busy);

    p_half_weight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cp_code[CODE_W-1] |-> (cp_weight == 1));
endmodule

bind fastlock_ctrl fastlock_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .freq_change(freq_change),
    .pll_en(pll_en), .fast_en(fast_en), .cp_norm(cp_norm), .cp_boost(cp_boost),
    .cp_code(cp_code), .loop_sw(loop_sw), .busy(busy), .cp_weight(cp_weight)
);

// File: tb/fastlock_ctrl_tb.sv
module fastlock_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfd_tick = 1'b0, freq_change = 1'b0, pll_en = 1'b0, fast_en = 1'b0;
    logic [12:0] fast_len = 13'd5;
    logic [3:0]  cp_norm = 4'd2, cp_boost = 4'd7;
    logic [3:0]  cp_code;
    logic        loop_sw, busy;
    logic [4:0]  cp_weight;

    int checks = 0, errors = 0, tick_per = 1, tick_cnt = 0;
    bit m_act = 0, m_prev = 0, done = 0;
    int m_rem = 0;
    string req = "R1";

    fastlock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .freq_change(freq_change),
        .pll_en(pll_en), .fast_en(fast_en), .fast_len(fast_len), .cp_norm(cp_norm),
        .cp_boost(cp_boost), .cp_code(cp_code), .loop_sw(loop_sw), .busy(busy),
        .cp_weight(cp_weight)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int wt(input logic [3:0] c);
        return c[3] ? 1 : 2 * (int'(c) + 1);
    endfunction

    task automatic check_bit(input string r, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, nm, act, exp);
        end
    endtask

    task automatic compare();
        bit e_busy;
        logic [3:0] e_code;
        e_busy = m_act && fast_en && pll_en;
        e_code = e_busy ? cp_boost : cp_norm;
        check_bit(req, "busy", int'(busy), int'(e_busy));
        check_bit(req, "loop_sw", int'(loop_sw), int'(e_busy));
        check_bit(req, "cp_code", int'(cp_code), int'(e_code));
        check_bit(req, "cp_weight", int'(cp_weight), wt(e_code));
    endtask

    // one clock: model updates at the edge, outputs compared at the falling edge
    task automatic step();
        pfd_tick = (tick_cnt % tick_per) == 0;
        tick_cnt++;
        @(posedge clk);
        if (rst_n) begin
            if (!fast_en || !pll_en) m_act = 0;
            else if (freq_change || !m_prev) begin
                m_act = 1;
                m_rem = (fast_len == 0) ? 1 : int'(fast_len);
            end else if (m_act && pfd_tick) begin
                if (m_rem == 1) m_act = 0;
                else m_rem--;
            end
            m_prev = pll_en;
        end
        @(negedge clk);
        compare();
        freq_change = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_change();
        freq_change = 1'b1;
        step();
    endtask

    initial begin
        int len_seen;
        repeat (3) @(negedge clk);
        req = "R1";
        compare();
        rst_n = 1'b1;
        run(2);

        req = "R3"; fast_en = 1; fast_len = 5; tick_per = 3; tick_cnt = 1;
        pll_en = 1; run(25);

        req = "R2"; fast_len = 3; tick_per = 1; pulse_change(); run(6);

        req = "R5"; fast_len = 4; tick_per = 1;
        pulse_change();
        len_seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (busy) len_seen++;
            step();
        end
        check_bit("R5", "window_cycles", len_seen, 4);

        req = "R6"; fast_len = 0; tick_per = 2; tick_cnt = 1; pulse_change(); run(6);

        req = "R7"; fast_len = 6; tick_per = 2; tick_cnt = 1;
        pulse_change(); run(5); pulse_change(); run(4);
        tick_per = 1; pulse_change(); run(9);

        req = "R8"; fast_len = 20; tick_per = 4; pulse_change(); run(3);
        fast_en = 0; run(3); pulse_change(); run(3);
        fast_en = 1; run(2); pulse_change(); run(3);

        req = "R9"; pll_en = 0; run(3); pulse_change(); run(2);
        pll_en = 1; run(4);

        req = "R4"; cp_norm = 4'd8; cp_boost = 4'd0; fast_len = 3; pulse_change(); run(14);

        req = "R10"; fast_len = 1; tick_per = 1000;
        for (int c = 0; c < 16; c++) begin
            cp_norm = 4'(c); cp_boost = 4'(15 - c);
            run(1); pulse_change(); run(1);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule